// File: doc/BRIEF.md
# GPIO Controller with Level-Match Interrupts

This block is a parameterized general-purpose pin controller sitting on a simple word-addressed register bus. Each pin can be handed either to software-controlled GPIO or to an alternate on-chip peripheral. When a pin is under GPIO control, software chooses whether the pin is an input or an output. Software drives output levels through a data register. Reading that same register returns the synchronized state of the pins.

Every pin has a programmable match level and a sticky status bit. The status bit is set whenever the synchronized pin value equals its match level. It stays set until software writes the status register. A per-pin enable steers each pending status bit to one of two lines. When the enable bit is set, the bit drives the non-maskable line. When it is clear, the bit drives the normal interrupt line. Pad cells, the bus decoder and the peripherals themselves live outside the block. The peripherals connect through plain per-pin input and output vectors.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is high and on the first edge after it, `pin_oe`, `irq` and `nmi` are 0. After reset, the function-select, direction, level and NMI-enable registers read back as 0.
- R2: Word index 0 is function select, 1 is direction, 2 is data, 3 is match level, 4 is status, and 5 is NMI enable. Indices 6 and 7 read as zero, and writes to them change no register.
- R3: A function-select bit of 1 routes `alt_out`/`alt_oe` of that pin to `pin_out`/`pin_oe`. A bit of 0 routes the GPIO data and direction bits. The pin outputs are registered, so they follow the select one edge after the register changes.
- R4: Under GPIO control, a direction bit of 1 enables the output driver with the data-register bit. A direction bit of 0 disables the driver.
- R5: Reading index 2 returns the pin inputs after a two-flop synchronizer, not the value software last wrote to the data register.
- R6: `alt_in` carries the synchronized pin values for every pin, whatever the function select.
- R7: A status bit becomes 1 on the edge after the synchronized pin equals its match-level bit.
- R8: Status bits are sticky: a set bit stays set after the pin stops matching. A bus write to index 4 loads the written value.
- R9: When a bus write to the status register and a match on the same bit fall in the same cycle, the bit ends up set.
- R10: `nmi` is the registered OR of the status bits whose NMI enable is 1. `irq` is the registered OR of the status bits whose NMI enable is 0.
- R11: Read data appears on `bus_rdata` on the edge after a read request (`bus_en` high, `bus_we` low) and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Level to drive on each pad |
| pin_oe | output | NPINS | Output-driver enable per pad |
| alt_out | input | NPINS | Output levels from the alternate peripherals |
| alt_oe | input | NPINS | Driver enables from the alternate peripherals |
| alt_in | output | NPINS | Synchronized pin levels to the peripherals |
| irq | output | 1 | Normal interrupt line |
| nmi | output | 1 | Non-maskable interrupt line |

## Verification
The properties assume that reset is held for at least one edge before the first bus access. They also assume that bus inputs are stable around each rising edge. The bench drives every input on the falling edge and holds reset for several cycles, which keeps within both assumptions. The pins are modeled as a loopback: a driven pin reflects `pin_out`, and an undriven pin takes an externally chosen pattern. Every pattern the bench applies is held for at least three edges before it is checked, so the synchronizer has fully settled before the level-match and readback expectations are evaluated.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int BUS_DW = 32;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    PB_FUNC  = 3'd0,
    PB_DIR   = 3'd1,
    PB_DATA  = 3'd2,
    PB_LEVEL = 3'd3,
    PB_STAT  = 3'd4,
    PB_NMIEN = 3'd5,
    PB_RSV6  = 3'd6,
    PB_RSV7  = 3'd7
  } pb_reg_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [N-1:0]      pins_sync,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      func_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      dout_q,
  output logic [N-1:0]      level_q,
  output logic [N-1:0]      nmien_q,
  output logic              stat_we,
  output logic [N-1:0]      stat_wdata,
  output logic [BUS_DW-1:0] rdata_q
);
  pb_reg_e     sel;
  logic        wr, rd;
  logic [BUS_DW-1:0] rd_mux;

  assign sel        = pb_reg_e'(bus_addr);
  assign wr         = bus_en && bus_we;
  assign rd         = bus_en && !bus_we;
  assign stat_we    = wr && (sel == PB_STAT);
  assign stat_wdata = bus_wdata[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q  <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      level_q <= '0;
      nmien_q <= '0;
    end else if (wr) begin
      case (sel)
        PB_FUNC:  func_q  <= bus_wdata[N-1:0];
        PB_DIR:   dir_q   <= bus_wdata[N-1:0];
        PB_DATA:  dout_q  <= bus_wdata[N-1:0];
        PB_LEVEL: level_q <= bus_wdata[N-1:0];
        PB_NMIEN: nmien_q <= bus_wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      PB_FUNC:  rd_mux[N-1:0] = func_q;
      PB_DIR:   rd_mux[N-1:0] = dir_q;
      PB_DATA:  rd_mux[N-1:0] = pins_sync;
      PB_LEVEL: rd_mux[N-1:0] = level_q;
      PB_STAT:  rd_mux[N-1:0] = status;
      PB_NMIEN: rd_mux[N-1:0] = nmien_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_sync,
  input  logic [N-1:0] level,
  input  logic [N-1:0] nmien,
  input  logic         stat_we,
  input  logic [N-1:0] stat_wdata,
  output logic [N-1:0] status_q,
  output logic [N-1:0] hit,
  output logic         irq_q,
  output logic         nmi_q
);
  logic [N-1:0] base;

  assign hit  = ~(pins_sync ^ level);
  assign base = stat_we ? stat_wdata : status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= base | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= |(status_q & ~nmien);
      nmi_q <= |(status_q & nmien);
    end
  end
endmodule

// File: rtl/pinbank_padmux.sv
module pinbank_padmux #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] func,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] dout,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (func[i]) begin
        pin_out[i] <= alt_out[i];
        pin_oe[i]  <= alt_oe[i];
      end else begin
        pin_out[i] <= dout[i];
        pin_oe[i]  <= dir[i];
      end
    end
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq,
  output logic              nmi
);
  logic [NPINS-1:0] pins_sync;
  logic [NPINS-1:0] func_q, dir_q, dout_q, level_q, nmien_q;
  logic [NPINS-1:0] stat_q, stat_wdata, hit_vec;
  logic             stat_we;

  pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  pinbank_regs #(.N(NPINS)) regs_i (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pins_sync(pins_sync), .status(stat_q),
    .func_q(func_q), .dir_q(dir_q), .dout_q(dout_q), .level_q(level_q),
    .nmien_q(nmien_q), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .rdata_q(bus_rdata)
  );

  pinbank_irq #(.N(NPINS)) irq_i (
    .clk(clk), .rst(rst), .pins_sync(pins_sync), .level(level_q),
    .nmien(nmien_q), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .status_q(stat_q), .hit(hit_vec), .irq_q(irq), .nmi_q(nmi)
  );

  pinbank_padmux #(.N(NPINS)) mux_i (
    .clk(clk), .rst(rst), .func(func_q), .dir(dir_q), .dout(dout_q),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign alt_in = pins_sync;
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] status,
  input logic [N-1:0] hit,
  input logic         stat_we,
  input logic [N-1:0] nmien,
  input logic [N-1:0] func,
  input logic [N-1:0] dir,
  input logic [N-1:0] alt_oe,
  input logic [N-1:0] pin_oe,
  input logic         irq,
  input logic         nmi
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && !irq && !nmi));

  assert_oe_route_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_oe == $past((func & alt_oe) | (~func & dir)));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stat_we)) |-> ((status & $past(status)) == $past(status)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status & $past(hit)) == $past(hit)));

  assert_nmi_route_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (nmi == $past(|(status & nmien))));

  assert_irq_route_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(status & ~nmien))));
endmodule

bind pinbank_ctrl pinbank_chk #(.N(NPINS)) chk_i (
  .clk(clk), .rst(rst), .status(stat_q), .hit(hit_vec), .stat_we(stat_we),
  .nmien(nmien_q), .func(func_q), .dir(dir_q), .alt_oe(alt_oe),
  .pin_oe(pin_oe), .irq(irq), .nmi(nmi)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int NP     = 8;
  localparam logic [NP-1:0] MASK = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, alt_in;
  logic [NP-1:0] alt_out = '0, alt_oe = '0, ext = '0;
  logic          irq, nmi;
  int            total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  pinbank_ctrl #(.NPINS(NP)) dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq(irq), .nmi(nmi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    ext = 8'h3C;
    idle(3);
    // R1: outputs quiet during reset
    check("R1 pin_oe in reset", {24'd0, pin_oe}, 32'd0);
    check("R1 irq/nmi in reset", {30'd0, irq, nmi}, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 pin_oe after release", {24'd0, pin_oe}, 32'd0);
    rd(3'd0, r); check("R1 func reset", r, 32'd0);
    rd(3'd1, r); check("R1 dir reset", r, 32'd0);
    rd(3'd3, r); check("R1 level reset", r, 32'd0);
    rd(3'd5, r); check("R1 nmien reset", r, 32'd0);

    // R2: map readback and reserved slots
    wr(3'd0, 32'h0000_0011); wr(3'd1, 32'h0000_0022);
    wr(3'd3, 32'h0000_0033); wr(3'd5, 32'h0000_0044);
    wr(3'd6, 32'h0000_00FF); wr(3'd7, 32'h0000_00FF);
    rd(3'd0, r); check("R2 func idx0", r, 32'h11);
    rd(3'd1, r); check("R2 dir idx1", r, 32'h22);
    rd(3'd3, r); check("R2 level idx3", r, 32'h33);
    rd(3'd5, r); check("R2 nmien idx5", r, 32'h44);
    rd(3'd6, r); check("R2 idx6 zero", r, 32'd0);
    rd(3'd7, r); check("R2 idx7 zero", r, 32'd0);
    // R11: read data holds with no new read
    idle(3); check("R11 rdata held", bus_rdata, 32'd0);
    rd(3'd1, r); idle(2); check("R11 rdata held after read", bus_rdata, 32'h22);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd5, 0);

    // R5: data readback is pins, not the written value
    wr(3'd2, 32'hFF); ext = 8'h12; idle(3);
    rd(3'd2, r); check("R5 data reads pins", r, 32'h12);
    // R4: output drive with loopback
    wr(3'd2, 32'h3C); wr(3'd1, 32'hFF); idle(4);
    check("R4 oe all", {24'd0, pin_oe}, 32'hFF);
    check("R4 out data", {24'd0, pin_out}, 32'h3C);
    rd(3'd2, r); check("R5 loopback readback", r, 32'h3C);
    wr(3'd1, 32'h00); idle(2);
    check("R4 oe cleared", {24'd0, pin_oe}, 32'h00);

    // R3: sweep of function select
    wr(3'd1, 32'hF0); wr(3'd2, 32'hCC);
    alt_out = 8'hAA; alt_oe = 8'h0F; ext = 8'h00;
    for (int f = 0; f < 256; f++) begin
      wr(3'd0, f); idle(1);
      check("R3 oe route", {24'd0, pin_oe}, {24'd0, (~f[7:0] & 8'hF0) | (f[7:0] & 8'h0F)});
      check("R3 out route", {24'd0, pin_out}, {24'd0, (~f[7:0] & 8'hCC) | (f[7:0] & 8'hAA)});
    end
    wr(3'd0, 0); wr(3'd1, 0); alt_oe = '0; idle(2);

    // R7/R6: exhaustive level-match sweep
    wr(3'd3, 32'hA5);
    for (int p = 0; p < 256; p++) begin
      ext = p[7:0]; idle(3);
      wr(3'd4, 0);
      rd(3'd4, r); check("R7 match status", r, {24'd0, ~(p[7:0] ^ 8'hA5) & MASK});
      check("R6 alt_in", {24'd0, alt_in}, {24'd0, p[7:0]});
    end

    // R8/R9: sticky, set-wins, load
    wr(3'd3, 32'h00); ext = 8'h0F; idle(3);
    wr(3'd4, 0);
    rd(3'd4, r); check("R9 set wins over clear", r, 32'hF0);
    ext = 8'hFF; idle(4);
    rd(3'd4, r); check("R8 sticky after mismatch", r, 32'hF0);
    wr(3'd4, 0);
    rd(3'd4, r); check("R8 write clears", r, 32'h00);
    wr(3'd4, 32'h5A);
    rd(3'd4, r); check("R8 write loads", r, 32'h5A);

    // R10: interrupt steering
    wr(3'd4, 0); idle(2);
    check("R10 both idle", {30'd0, irq, nmi}, 32'd0);
    wr(3'd5, 32'h10); wr(3'd4, 32'h10); idle(2);
    check("R10 nmi steered", {30'd0, irq, nmi}, 32'd1);
    wr(3'd5, 32'h00); idle(2);
    check("R10 irq steered", {30'd0, irq, nmi}, 32'd2);
    wr(3'd5, 32'h11); wr(3'd4, 32'h03); idle(2);
    check("R10 split", {30'd0, irq, nmi}, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule